// File: doc/BRIEF.md
# Sound Frame Sequencer with Interrupt Flag

This block divides the CPU clock into the quarter-frame and half-frame strobes that pace the envelopes, sweeps and length counters of a sound unit. It also raises a frame interrupt at the end of each frame in the 4-step sequence. Software writes a mode word that selects the 4-step or 5-step sequence and can inhibit the interrupt. A status-read strobe samples the interrupt flag and schedules it to be cleared.

The block tracks CPU-cycle parity. After reset, cycle k has parity k mod 2. Odd cycles are "put" half-periods and even cycles are "get" half-periods. Parity sets two things: how long a mode write takes before the divider restarts, and the edge on which a status read clears the flag. Positions are counted in cycles since the divider last restarted. Position 0 is the cycle that follows reset release or a restart. The step positions STEP1, STEP2, STEP3, FLAG_SET and STEP5 are parameters.

Top module: `frame_seq_irq`

## Requirements
- R1: During reset and in the first cycle after it, all four outputs are low. Reset selects the 4-step sequence with the interrupt not inhibited.
- R2: In the 4-step sequence the frame lasts FLAG_SET+2 cycles. The quarter strobe is high at positions STEP1, STEP2, STEP3 and FLAG_SET+1. The half strobe is high at STEP2 and FLAG_SET+1. No strobe is high at any other position.
- R3: In the 5-step sequence the frame lasts STEP5+1 cycles. The quarter strobe is high at STEP1, STEP2, STEP3 and STEP5. The half strobe is high at STEP2 and STEP5. Nothing fires at position FLAG_SET+1.
- R4: In the 4-step sequence, with the interrupt not inhibited, the flag is low at position FLAG_SET-1. It is high from FLAG_SET onward and stays high until it is cleared. irq_o is high whenever the flag is high.
- R5: With the interrupt inhibited, the flag is high only at positions FLAG_SET and FLAG_SET+1 and is low at FLAG_SET+2. irq_o stays low throughout.
- R6: In the 5-step sequence the flag never becomes set.
- R7: A status read clears the flag on the first put-to-get edge at or after the read. A read in a put cycle clears the flag on that cycle's closing edge. A read in a get cycle clears it one edge later.
- R8: A clear that lands on or before the last set edge is overridden, and the flag ends up set. The last set edge closes position FLAG_SET+1. A clear that lands on a later edge leaves the flag low.
- R9: A mode write with the inhibit bit set clears the flag on the write edge. A mode write with the inhibit bit clear, including a switch to the 5-step sequence, leaves the flag unchanged.
- R10: A mode write restarts the divider with the new sequence. The restart comes 3 edges after a write in a put cycle and 4 edges after a write in a get cycle, counting the write edge. The new position 0 is visible after that edge. Until then the old sequence keeps running.
- R11: The restart cycle of a write that selects the 5-step sequence has both strobes high. A write that selects the 4-step sequence produces no strobe at restart.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | CPU clock, one edge per CPU cycle |
| rst_ni | input | 1 | Active-low asynchronous reset |
| mode_wr_i | input | 1 | Mode-word write strobe |
| mode5_i | input | 1 | Mode word: 1 selects the 5-step sequence, 0 the 4-step sequence |
| irq_inhibit_i | input | 1 | Mode word: 1 inhibits the frame interrupt |
| status_rd_i | input | 1 | Status-read strobe that schedules the flag clear |
| qtr_frame_o | output | 1 | Quarter-frame strobe |
| half_frame_o | output | 1 | Half-frame strobe |
| frame_flag_o | output | 1 | Frame interrupt flag as sampled by a status read |
| irq_o | output | 1 | Active-high interrupt request |

## Verification
The bench builds the block with STEP1=75, STEP2=149, STEP3=224, FLAG_SET=298 and STEP5=373. The delays stay at 3 and 4. These small values keep the scan short. Every strobe position of both sequences, the frame wrap and the three-cycle set window can then be scanned cycle by cycle across more than one frame. Status reads are placed at each position around the set window, on both parities. Mode writes are made on both parities.

// File: rtl/frame_seq_pkg.sv
package frame_seq_pkg;
  typedef enum logic {
    SEQ_4STEP = 1'b0,
    SEQ_5STEP = 1'b1
  } seq_mode_e;

  typedef enum logic {
    HALF_GET = 1'b0,
    HALF_PUT = 1'b1
  } half_e;
endpackage

// File: rtl/fs_cfg_sync.sv
module fs_cfg_sync
  import frame_seq_pkg::*;
#(
  parameter int PUT_DLY = 3,
  parameter int GET_DLY = 4
) (
  input  logic      clk_i,
  input  logic      rst_ni,
  input  logic      wr_i,
  input  logic      mode5_i,
  input  logic      inhibit_i,
  output half_e     par_o,
  output logic      restart_o,
  output seq_mode_e new_mode_o,
  output logic      inhibit_o,
  output logic      inh_wr_o
);
  localparam int LW = $clog2(GET_DLY) + 1;
  localparam logic [LW-1:0] PUT_LOAD = LW'(PUT_DLY - 2);
  localparam logic [LW-1:0] GET_LOAD = LW'(GET_DLY - 2);

  half_e           par_q;
  logic            pend_q;
  logic [LW-1:0]   left_q;
  seq_mode_e       nmode_q;
  logic            inhibit_q;

  assign restart_o  = pend_q && (left_q == '0);
  assign par_o      = par_q;
  assign new_mode_o = nmode_q;
  assign inhibit_o  = inhibit_q;
  assign inh_wr_o   = wr_i && inhibit_i;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      par_q     <= HALF_GET;
      pend_q    <= 1'b0;
      left_q    <= '0;
      nmode_q   <= SEQ_4STEP;
      inhibit_q <= 1'b0;
    end else begin
      par_q <= (par_q == HALF_PUT) ? HALF_GET : HALF_PUT;
      if (wr_i) begin
        pend_q    <= 1'b1;
        left_q    <= (par_q == HALF_PUT) ? PUT_LOAD : GET_LOAD;
        nmode_q   <= mode5_i ? SEQ_5STEP : SEQ_4STEP;
        inhibit_q <= inhibit_i;
      end else if (restart_o) begin
        pend_q <= 1'b0;
      end else if (pend_q) begin
        left_q <= left_q - 1'b1;
      end
    end
  end

  // R10
  restart_gap_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wr_i |=> !restart_o);

  // R10
  par_alt_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    par_q == HALF_PUT |=> par_q == HALF_GET);
endmodule

// File: rtl/fs_divider.sv
module fs_divider
  import frame_seq_pkg::*;
#(
  parameter int STEP1    = 7457,
  parameter int STEP2    = 14913,
  parameter int STEP3    = 22371,
  parameter int FLAG_SET = 29828,
  parameter int STEP5    = 37281,
  parameter int CNT_W    = $clog2(STEP5 + 1)
) (
  input  logic      clk_i,
  input  logic      rst_ni,
  input  logic      restart_i,
  input  seq_mode_e new_mode_i,
  output seq_mode_e mode_o,
  output logic      qtr_o,
  output logic      half_o,
  output logic      set_a_o,
  output logic      set_b_o
);
  localparam int NCOMMON = 3;
  localparam logic [CNT_W-1:0] C_F0 = CNT_W'(FLAG_SET - 1);
  localparam logic [CNT_W-1:0] C_F1 = CNT_W'(FLAG_SET);
  localparam logic [CNT_W-1:0] C_L4 = CNT_W'(FLAG_SET + 1);
  localparam logic [CNT_W-1:0] C_L5 = CNT_W'(STEP5);
  localparam logic [CNT_W-1:0] C_H  = CNT_W'(STEP2);

  logic [CNT_W-1:0] cnt_q;
  seq_mode_e        mode_q;
  logic             boot_q;
  logic [NCOMMON-1:0] common_hit;
  logic             last_hit;
  logic             wrap;

  // shared step positions of both sequences
  for (genvar g = 0; g < NCOMMON; g++) begin : g_common
    localparam int POS = (g == 0) ? STEP1 : (g == 1) ? STEP2 : STEP3;
    assign common_hit[g] = (cnt_q == CNT_W'(POS));
  end

  assign last_hit = (mode_q == SEQ_4STEP) ? (cnt_q == C_L4) : (cnt_q == C_L5);
  assign wrap     = last_hit;

  assign qtr_o   = (|common_hit) | last_hit | boot_q;
  assign half_o  = (cnt_q == C_H) | last_hit | boot_q;
  assign set_a_o = (mode_q == SEQ_4STEP) && ((cnt_q == C_F0) || (cnt_q == C_F1));
  assign set_b_o = (mode_q == SEQ_4STEP) && (cnt_q == C_L4);
  assign mode_o  = mode_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q  <= '0;
      mode_q <= SEQ_4STEP;
      boot_q <= 1'b0;
    end else begin
      boot_q <= 1'b0;
      if (restart_i) begin
        cnt_q  <= '0;
        mode_q <= new_mode_i;
        boot_q <= (new_mode_i == SEQ_5STEP);
      end else if (wrap) begin
        cnt_q <= '0;
      end else begin
        cnt_q <= cnt_q + 1'b1;
      end
    end
  end

  // R2
  half_has_qtr_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    half_o |-> qtr_o);

  // R3
  cnt_bound_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cnt_q <= C_L5);

  // R2
  cnt4_bound_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    mode_q == SEQ_4STEP |-> cnt_q <= C_L4);
endmodule

// File: rtl/fs_irq_flag.sv
module fs_irq_flag
  import frame_seq_pkg::*;
(
  input  logic  clk_i,
  input  logic  rst_ni,
  input  logic  set_a_i,
  input  logic  set_b_i,
  input  logic  inhibit_i,
  input  logic  inh_wr_i,
  input  logic  rd_i,
  input  half_e par_i,
  output logic  flag_o,
  output logic  irq_o
);
  logic flag_q;
  logic clr_pend_q;
  logic clr_req;
  logic clr_now;
  logic set_now;

  assign clr_req = rd_i || clr_pend_q;
  assign clr_now = clr_req && (par_i == HALF_PUT);
  // third set cycle is masked while inhibited
  assign set_now = set_a_i || (set_b_i && !inhibit_i);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      flag_q     <= 1'b0;
      clr_pend_q <= 1'b0;
    end else begin
      clr_pend_q <= clr_req && (par_i == HALF_GET);
      if (set_now)                            flag_q <= 1'b1;
      else if (inhibit_i || inh_wr_i || clr_now) flag_q <= 1'b0;
    end
  end

  assign flag_o = flag_q;
  assign irq_o  = flag_q && !inhibit_i;

  // R4
  flag_rise_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(flag_q) |-> $past(set_a_i || set_b_i));

  // R7
  clear_phase_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ($fell(flag_q) && !$past(inhibit_i) && !$past(inh_wr_i)) |-> $past(par_i) == HALF_PUT);

  // R5
  inhibit_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (inhibit_i && !set_a_i && !inh_wr_i) |=> !flag_q || $past(set_b_i));
endmodule

// File: rtl/frame_seq_irq.sv
module frame_seq_irq
  import frame_seq_pkg::*;
#(
  parameter int STEP1    = 7457,
  parameter int STEP2    = 14913,
  parameter int STEP3    = 22371,
  parameter int FLAG_SET = 29828,
  parameter int STEP5    = 37281,
  parameter int PUT_DLY  = 3,
  parameter int GET_DLY  = 4
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic mode_wr_i,
  input  logic mode5_i,
  input  logic irq_inhibit_i,
  input  logic status_rd_i,
  output logic qtr_frame_o,
  output logic half_frame_o,
  output logic frame_flag_o,
  output logic irq_o
);
  localparam int CNT_W = $clog2(STEP5 + 1);

  half_e     par;
  logic      restart;
  seq_mode_e new_mode;
  seq_mode_e mode;
  logic      inhibit;
  logic      inh_wr;
  logic      set_a;
  logic      set_b;

  fs_cfg_sync #(
    .PUT_DLY(PUT_DLY),
    .GET_DLY(GET_DLY)
  ) u_cfg (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .wr_i       (mode_wr_i),
    .mode5_i    (mode5_i),
    .inhibit_i  (irq_inhibit_i),
    .par_o      (par),
    .restart_o  (restart),
    .new_mode_o (new_mode),
    .inhibit_o  (inhibit),
    .inh_wr_o   (inh_wr)
  );

  fs_divider #(
    .STEP1    (STEP1),
    .STEP2    (STEP2),
    .STEP3    (STEP3),
    .FLAG_SET (FLAG_SET),
    .STEP5    (STEP5),
    .CNT_W    (CNT_W)
  ) u_div (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .restart_i  (restart),
    .new_mode_i (new_mode),
    .mode_o     (mode),
    .qtr_o      (qtr_frame_o),
    .half_o     (half_frame_o),
    .set_a_o    (set_a),
    .set_b_o    (set_b)
  );

  fs_irq_flag u_flag (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .set_a_i   (set_a),
    .set_b_i   (set_b),
    .inhibit_i (inhibit),
    .inh_wr_i  (inh_wr),
    .rd_i      (status_rd_i),
    .par_i     (par),
    .flag_o    (frame_flag_o),
    .irq_o     (irq_o)
  );

  // R6
  five_no_set_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (mode == SEQ_5STEP && !frame_flag_o) |=> !frame_flag_o);

  // R11
  boot_mode_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (restart && new_mode == SEQ_4STEP) |=> !qtr_frame_o);
endmodule

// File: tb/frame_seq_irq_bench.sv
module frame_seq_irq_bench;
  localparam int CLK_PERIOD = 10;
  localparam int S1 = 75;
  localparam int S2 = 149;
  localparam int S3 = 224;
  localparam int FS = 298;
  localparam int S5 = 373;
  localparam int P4 = FS + 2;
  localparam int P5 = S5 + 1;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic wr = 1'b0, m5 = 1'b0, inh = 1'b0, rd = 1'b0;
  logic qtr, half, flag, irq;

  int checks = 0;
  int fails = 0;
  int edges = 0;
  int pos = 0;
  bit cur_m5 = 1'b0;
  bit done = 1'b0;

  frame_seq_irq #(
    .STEP1(S1), .STEP2(S2), .STEP3(S3), .FLAG_SET(FS), .STEP5(S5)
  ) u_frame_seq_irq (
    .clk_i(clk), .rst_ni(rst_n), .mode_wr_i(wr), .mode5_i(m5),
    .irq_inhibit_i(inh), .status_rd_i(rd),
    .qtr_frame_o(qtr), .half_frame_o(half), .frame_flag_o(flag), .irq_o(irq)
  );

  always #(CLK_PERIOD / 2) clk = ~clk;

  task automatic chk(string req, logic act, logic exp, string what);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s %s: actual %0b expected %0b (pos %0d)", req, what, act, exp, pos);
    end
  endtask

  task automatic tick();
    @(posedge clk);
    @(negedge clk);
    edges++;
    pos++;
  endtask

  function automatic bit is_put();
    return (edges % 2) == 1;
  endfunction

  function automatic bit exp_q(int p, bit five);
    int c;
    c = five ? (p % P5) : (p % P4);
    if (c == S1 || c == S2 || c == S3) return 1'b1;
    return five ? (c == S5) : (c == FS + 1);
  endfunction

  function automatic bit exp_h(int p, bit five);
    int c;
    c = five ? (p % P5) : (p % P4);
    if (c == S2) return 1'b1;
    return five ? (c == S5) : (c == FS + 1);
  endfunction

  task automatic run_to(int p);
    while (pos < p) tick();
  endtask

  // scan strobes cycle by cycle; optionally the flag must stay low
  task automatic scan(int upto, string req, bit flag_low);
    while (pos < upto) begin
      tick();
      chk(req, qtr, exp_q(pos, cur_m5), "quarter strobe");
      chk(req, half, exp_h(pos, cur_m5), "half strobe");
      if (flag_low) chk("R6", flag, 1'b0, "flag in 5-step");
    end
  endtask

  task automatic mode_write(bit five, bit inhib, bit want_put);
    int d;
    if (is_put() != want_put) tick();
    wr = 1'b1; m5 = five; inh = inhib;
    d = want_put ? 3 : 4;
    tick();
    wr = 1'b0; m5 = 1'b0; inh = 1'b0;
    if (inhib) chk("R9", flag, 1'b0, "flag after inhibit write");
    repeat (d - 2) tick();
    chk("R10", qtr, exp_q(pos, cur_m5), "old sequence before restart");
    tick();
    pos = 0;
    cur_m5 = five;
    chk("R11", qtr, five, "quarter at restart");
    chk("R11", half, five, "half at restart");
  endtask

  task automatic t_reset();
    chk("R1", qtr, 1'b0, "quarter in reset");
    chk("R1", flag, 1'b0, "flag in reset");
    @(negedge clk);
    rst_n = 1'b1;
    edges = 0;
    pos = 0;
    chk("R1", qtr, 1'b0, "quarter after reset");
    chk("R1", half, 1'b0, "half after reset");
    chk("R1", flag, 1'b0, "flag after reset");
    chk("R1", irq, 1'b0, "irq after reset");
  endtask

  task automatic t_four_step();
    scan(FS - 1, "R2", 1'b0);
    chk("R4", flag, 1'b0, "flag one before set");
    scan(FS, "R2", 1'b0);
    chk("R4", flag, 1'b1, "flag first set cycle");
    chk("R4", irq, 1'b1, "irq first set cycle");
    scan(FS + 2, "R2", 1'b0);
    chk("R4", flag, 1'b1, "flag third set cycle");
    scan(P4 + S3 + 2, "R2", 1'b0);
    chk("R4", flag, 1'b1, "flag sticky");
    chk("R4", irq, 1'b1, "irq sticky");
  endtask

  task automatic t_inhibit();
    mode_write(1'b0, 1'b1, 1'b1);
    scan(FS - 1, "R2", 1'b0);
    chk("R5", flag, 1'b0, "inhibited flag before set");
    tick();
    chk("R5", flag, 1'b1, "inhibited flag first");
    chk("R5", irq, 1'b0, "inhibited irq first");
    tick();
    chk("R5", flag, 1'b1, "inhibited flag second");
    chk("R5", irq, 1'b0, "inhibited irq second");
    tick();
    chk("R5", flag, 1'b0, "inhibited flag third");
    chk("R5", irq, 1'b0, "inhibited irq third");
  endtask

  task automatic t_read_clear();
    mode_write(1'b0, 1'b0, 1'b0);
    run_to(FS + 3);
    chk("R4", flag, 1'b1, "flag set before reads");
    if (is_put()) tick();
    rd = 1'b1;
    tick();
    rd = 1'b0;
    chk("R7", flag, 1'b1, "get read not yet cleared");
    tick();
    chk("R7", flag, 1'b0, "get read cleared at put-get");
    mode_write(1'b0, 1'b0, 1'b1);
    run_to(FS + 3);
    if (!is_put()) tick();
    rd = 1'b1;
    tick();
    rd = 1'b0;
    chk("R7", flag, 1'b0, "put read cleared at once");
  endtask

  task automatic t_race();
    for (int off = 0; off < 5; off++) begin
      int c;
      int k;
      bit e;
      c = FS - 1 + off;
      mode_write(1'b0, 1'b0, off % 2 == 1);
      run_to(c);
      k = is_put() ? c : c + 1;
      rd = 1'b1;
      tick();
      rd = 1'b0;
      run_to(FS + 4);
      e = (k <= FS + 1);
      chk("R8", flag, e, $sformatf("read at pos %0d", c));
    end
  endtask

  task automatic t_five_step();
    mode_write(1'b0, 1'b0, 1'b1);
    run_to(FS + 3);
    chk("R4", flag, 1'b1, "flag set before switch");
    mode_write(1'b1, 1'b0, 1'b1);
    chk("R9", flag, 1'b1, "5-step switch keeps flag");
    rd = 1'b1;
    tick();
    rd = 1'b0;
    tick();
    chk("R7", flag, 1'b0, "read clears in 5-step");
    scan(P5 + S2 + 2, "R3", 1'b1);
    mode_write(1'b1, 1'b0, 1'b0);
    scan(S1 + 1, "R3", 1'b1);
    mode_write(1'b0, 1'b0, 1'b1);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    t_reset();
    t_four_step();
    t_inhibit();
    t_read_clear();
    t_race();
    t_five_step();
    done = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      checks++;
      fails++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end
endmodule